// File: doc/BRIEF.md
# Set-Associative Read-Allocate Cache

This block places a small cache between a processor that issues 32-bit word loads and stores and a slower next-level memory. The number of ways (one, two or four) and the number of sets (a power of two) are parameters, and each entry holds a single 32-bit word. A lookup reads the indexed set and compares every way's tag in parallel. A read hit completes in the cycle it is presented. A read miss stalls the requester while the word is fetched and written into the set, and the load is then retried and completes as a hit.

Stores are always sent on to the next level. A store that hits also updates the cached word. A store that misses leaves the cache untouched. When a line has to be replaced, an empty way is taken if the set has one; otherwise the way that was used least recently is taken. Hits, store hits included, and refills make the accessed way the most recently used one.

The requester raises `cpu_req` and holds `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready` is high at a rising clock edge. The next-level memory gets one command at a time and holds it until `mem_ack` is pulsed for one cycle. Read data on `mem_rdata` is valid in the cycle `mem_ack` is high.

Top module: `sa_cache`

## Requirements
- R1: Byte address bits [1:0] are ignored. The set is (address >> 2) modulo SETS and the tag is address >> (2 + log2(SETS)). Two addresses that differ only in bits [1:0] reach the same entry.
- R2: A read whose set holds a valid way with a matching tag raises `cpu_ready` in the same cycle as the request, returns the stored word and causes no next-level traffic.
- R3: At most one way matches in any cycle, and read data comes from the matching way.
- R4: On a read miss, `cpu_ready` stays low while one next-level read of the word-aligned address runs. The fetched word is installed, and the retried load completes with that word. Once the fill is done the same address hits.
- R5: Every store raises exactly one next-level write that carries the store word and the word-aligned address. `cpu_ready` rises in the cycle of its `mem_ack`.
- R6: A store that hits replaces the cached word. A later read of that address hits and returns the new word without a next-level read.
- R7: A store that misses allocates nothing, so a later read of that address misses and fetches the stored word.
- R8: A fill uses an invalid way of the set before it evicts any valid way. A set with WAYS distinct blocks read into it keeps all of them.
- R9: In a full set, a refill replaces the least recently used way. Read hits, store hits and refills each make the accessed way the most recently used.
- R10: After reset no entry is valid, `cpu_ready` and both next-level commands are low, and the first read of any address misses.
- R11: With four one-word entries and block reads 0, 8, 0, 6, 8, the hit pattern is: one way with four sets, all misses; two ways with two sets, miss, miss, hit, miss, miss; four ways with one set, miss, miss, hit, miss, hit.
- R12: Read and write commands are never raised together. A raised command stays raised until `mem_ack`. Each access issues at most one next-level transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this rising edge |
| cpu_rdata | output | 32 | Load data, valid when `cpu_ready` is high for a load |
| mem_rd_req | output | 1 | Next-level read command |
| mem_wr_req | output | 1 | Next-level write command |
| mem_addr | output | 32 | Word-aligned next-level address |
| mem_wdata | output | 32 | Next-level write data |
| mem_ack | input | 1 | One-cycle completion of the current command |
| mem_rdata | input | 32 | Next-level read data, valid with `mem_ack` |

## Verification
The bench runs four configurations, including the three four-entry shapes, and watches for how each ordering error would show up.
- A replacement policy that used fill order instead of recency, or that skipped the update on a store hit, would evict the wrong block, and a later access would miss where a hit is due.
- A store miss that allocated would turn the next read into a hit with no fetch.
- A store hit that did not update its entry would return the old word.
- A tag or index split that used the byte offset would send two offsets of one word to different entries.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_WRITE  = 2'd2
  } cache_state_e;

  // Width of a field that selects one of n items, at least one bit.
  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Set number of a byte address: word address modulo the set count.
  function automatic logic [31:0] set_of(logic [31:0] addr, int unsigned sets);
    return (addr >> 2) % sets;
  endfunction

  // Tag of a byte address: the bits above offset and index.
  function automatic logic [31:0] tag_of(logic [31:0] addr, int unsigned sets);
    return addr >> (2 + $clog2(sets));
  endfunction

  // Word-aligned form of a byte address.
  function automatic logic [31:0] word_align(logic [31:0] addr);
    return {addr[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/sa_cache_store.sv
module sa_cache_store #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 256,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 22
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0][31:0]       rd_data,
  input  logic                        fill_en,
  input  logic                        upd_en,
  input  logic [WAYS-1:0]             way_oh,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [31:0]                 wr_data
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [31:0]      dat_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (fill_en && way_oh[w]) begin
        vld_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && way_oh[w]) begin
        tag_q[idx] <= wr_tag;
      end
      if ((fill_en || upd_en) && way_oh[w]) begin
        dat_q[idx] <= wr_data;
      end
    end

    assign rd_valid[w] = vld_q[idx];
    assign rd_tag[w]   = tag_q[idx];
    assign rd_data[w]  = dat_q[idx];
  end

endmodule

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 22
) (
  input  logic [WAYS-1:0]             rd_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic [WAYS-1:0][31:0]       rd_data,
  input  logic [TAG_W-1:0]            req_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [31:0]                 hit_data
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
  end

  assign hit = |hit_vec;

  // And-or way multiplexer; hit_vec is one-hot or zero.
  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_data = hit_data | rd_data[w];
      end
    end
  end

endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 256,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AGE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             touch_en,
  input  logic [WAYS-1:0]  touch_oh,
  output logic [WAYS-1:0]  victim_oh
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  // Age 0 is most recently used, WAYS-1 least recently used.
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [AGE_W-1:0]           touch_age;
  logic                       free_found;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (touch_oh[w]) begin
        touch_age = touch_age | age_q[idx][w];
      end
    end
  end

  always_comb begin
    victim_oh  = '0;
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_vec[w] && !free_found) begin
        victim_oh[w] = 1'b1;
        free_found   = 1'b1;
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++) begin
        victim_oh[w] = (age_q[idx][w] == OLDEST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_oh[w]) begin
          age_q[idx][w] <= '0;
        end else if (age_q[idx][w] < touch_age) begin
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sa_cache_ctrl.sv
module sa_cache_ctrl
  import sa_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_req,
  input  logic         cpu_we,
  input  logic         hit,
  input  logic         mem_ack,
  output cache_state_e state,
  output logic         cpu_ready,
  output logic         mem_rd_req,
  output logic         mem_wr_req,
  output logic         fill_en,
  output logic         upd_en,
  output logic         touch_en
);

  cache_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cpu_ready  = 1'b0;
    mem_rd_req = 1'b0;
    mem_wr_req = 1'b0;
    fill_en    = 1'b0;
    upd_en     = 1'b0;
    touch_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && cpu_we) begin
          state_d = ST_WRITE;
        end else if (cpu_req && hit) begin
          cpu_ready = 1'b1;
          touch_en  = 1'b1;
        end else if (cpu_req) begin
          state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_rd_req = 1'b1;
        if (mem_ack) begin
          fill_en  = 1'b1;
          touch_en = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_WRITE: begin
        mem_wr_req = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          upd_en    = hit;
          touch_en  = hit;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_rd_req,
  output logic        mem_wr_req,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  localparam int unsigned IDX_W = sel_width(SETS);
  localparam int unsigned AGE_W = sel_width(WAYS);
  localparam int unsigned TAG_W = 30 - $clog2(SETS);

  // Named internal events, also seen by the bound checker.
  logic [IDX_W-1:0]            req_idx;
  logic [TAG_W-1:0]            req_tag;
  logic [WAYS-1:0]             set_valid;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0][31:0]       set_data;
  logic [WAYS-1:0]             hit_vec;
  logic [WAYS-1:0]             victim_oh;
  logic [WAYS-1:0]             access_oh;
  logic                        lookup_hit;
  logic [31:0]                 hit_data;
  logic                        fill_en;
  logic                        upd_en;
  logic                        touch_en;
  cache_state_e                state;

  assign req_idx = IDX_W'(set_of(cpu_addr, SETS));
  assign req_tag = TAG_W'(tag_of(cpu_addr, SETS));

  // A refill writes the victim way; a hit touches the matching way.
  assign access_oh = fill_en ? victim_oh : hit_vec;

  sa_cache_store #(
    .WAYS (WAYS),
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (req_idx),
    .rd_valid(set_valid),
    .rd_tag  (set_tag),
    .rd_data (set_data),
    .fill_en (fill_en),
    .upd_en  (upd_en),
    .way_oh  (access_oh),
    .wr_tag  (req_tag),
    .wr_data (fill_en ? mem_rdata : cpu_wdata)
  );

  sa_cache_lookup #(
    .WAYS (WAYS),
    .TAG_W(TAG_W)
  ) u_lookup (
    .rd_valid(set_valid),
    .rd_tag  (set_tag),
    .rd_data (set_data),
    .req_tag (req_tag),
    .hit_vec (hit_vec),
    .hit     (lookup_hit),
    .hit_data(hit_data)
  );

  sa_cache_lru #(
    .WAYS (WAYS),
    .SETS (SETS),
    .IDX_W(IDX_W),
    .AGE_W(AGE_W)
  ) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (req_idx),
    .valid_vec(set_valid),
    .touch_en (touch_en),
    .touch_oh (access_oh),
    .victim_oh(victim_oh)
  );

  sa_cache_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .hit       (lookup_hit),
    .mem_ack   (mem_ack),
    .state     (state),
    .cpu_ready (cpu_ready),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .fill_en   (fill_en),
    .upd_en    (upd_en),
    .touch_en  (touch_en)
  );

  assign cpu_rdata = hit_data;
  assign mem_addr  = word_align(cpu_addr);
  assign mem_wdata = cpu_wdata;

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int unsigned WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_we,
  input logic            cpu_ready,
  input logic            mem_rd_req,
  input logic            mem_wr_req,
  input logic            mem_ack,
  input logic            lookup_hit,
  input logic            fill_en,
  input logic [WAYS-1:0] hit_vec,
  input logic [WAYS-1:0] victim_oh
);

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req)); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ack) |=> mem_rd_req); // R12

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_ack) |=> mem_wr_req); // R12

  AST_STALL_ON_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !cpu_ready); // R4

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lookup_hit); // R4

  AST_LOAD_DONE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> lookup_hit); // R2

  AST_STORE_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_ack && mem_wr_req)); // R5

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> ($countones(victim_oh) == 1)); // R9

  AST_WRITE_ONLY_FOR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> cpu_we); // R5

endmodule

bind sa_cache sa_cache_chk #(.WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_we    (cpu_we),
  .cpu_ready (cpu_ready),
  .mem_rd_req(mem_rd_req),
  .mem_wr_req(mem_wr_req),
  .mem_ack   (mem_ack),
  .lookup_hit(lookup_hit),
  .fill_en   (fill_en),
  .hit_vec   (hit_vec),
  .victim_oh (victim_oh)
);

// File: tb/tb_sa_cache.sv
`timescale 1ns/1ps

package tb_cache_pkg;
  function automatic logic [31:0] init_word(int i);
    return 32'hA5A5_0000 ^ (i * 32'h0001_0103);
  endfunction
endpackage

module tb_nextlvl #(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output int          rd_cnt,
  output int          wr_cnt,
  output logic [31:0] last_addr,
  output logic [31:0] last_wdata
);
  logic [31:0] mem [64];
  int cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= tb_cache_pkg::init_word(i);
      ack <= 1'b0; cnt <= 0; rd_cnt <= 0; wr_cnt <= 0;
      rdata <= '0; last_addr <= '0; last_wdata <= '0;
    end else begin
      ack <= 1'b0;
      if ((rd_req || wr_req) && !ack) begin
        if (cnt == LAT) begin
          cnt <= 0;
          ack <= 1'b1;
          last_addr <= addr;
          if (rd_req) begin
            rdata  <= mem[addr[7:2]];
            rd_cnt <= rd_cnt + 1;
          end else begin
            mem[addr[7:2]] <= wdata;
            last_wdata     <= wdata;
            wr_cnt         <= wr_cnt + 1;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end
endmodule

module tb_sa_cache;
  import tb_cache_pkg::*;

  localparam int NCFG = 4;
  localparam int unsigned WV [NCFG] = '{4, 1, 2, 4};
  localparam int unsigned SV [NCFG] = '{4, 4, 2, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req   [NCFG];
  logic        we    [NCFG];
  logic [31:0] addr  [NCFG];
  logic [31:0] wdata [NCFG];
  logic        ready [NCFG];
  logic [31:0] rdata [NCFG];
  logic        mrd   [NCFG];
  logic        mwr   [NCFG];
  int          rdc   [NCFG];
  int          wrc   [NCFG];
  logic [31:0] lasta [NCFG];
  logic [31:0] lastw [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic        mack;
    logic [31:0] maddr, mwdata, mrdata;

    sa_cache #(.WAYS(WV[g]), .SETS(SV[g])) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[g]), .cpu_we(we[g]), .cpu_addr(addr[g]), .cpu_wdata(wdata[g]),
      .cpu_ready(ready[g]), .cpu_rdata(rdata[g]),
      .mem_rd_req(mrd[g]), .mem_wr_req(mwr[g]), .mem_addr(maddr), .mem_wdata(mwdata),
      .mem_ack(mack), .mem_rdata(mrdata)
    );

    tb_nextlvl #(.LAT(2)) u_mem (
      .clk(clk), .rst_n(rst_n), .rd_req(mrd[g]), .wr_req(mwr[g]), .addr(maddr),
      .wdata(mwdata), .ack(mack), .rdata(mrdata), .rd_cnt(rdc[g]), .wr_cnt(wrc[g]),
      .last_addr(lasta[g]), .last_wdata(lastw[g])
    );
  end

  int n_chk = 0;
  int n_fail = 0;

  // Reference: per config and set, block numbers ordered most recent first.
  int          stk   [NCFG][4][4];
  int          dep   [NCFG][4];
  logic [31:0] refmem[NCFG][64];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit ref_access(int k, bit w, int blk);
    int s = blk % int'(SV[k]);
    int pos = -1;
    int n;
    for (int i = 0; i < dep[k][s]; i++) if (stk[k][s][i] == blk) pos = i;
    if (pos >= 0) begin
      for (int i = pos; i > 0; i--) stk[k][s][i] = stk[k][s][i-1];
      stk[k][s][0] = blk;
      return 1'b1;
    end
    if (!w) begin
      n = (dep[k][s] < int'(WV[k])) ? dep[k][s] + 1 : int'(WV[k]);
      for (int i = n - 1; i > 0; i--) stk[k][s][i] = stk[k][s][i-1];
      stk[k][s][0] = blk;
      dep[k][s] = n;
    end
    return 1'b0;
  endfunction

  task automatic access(input int k, input bit w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc, output int drd, output int dwr);
    int r0, w0;
    @(negedge clk);
    r0 = rdc[k]; w0 = wrc[k];
    req[k] = 1'b1; we[k] = w; addr[k] = a; wdata[k] = d; cyc = 0;
    forever begin
      #1;
      cyc++;
      if (ready[k]) break;
      @(negedge clk);
    end
    rd = rdata[k];
    @(negedge clk);
    req[k] = 1'b0; we[k] = 1'b0;
    drd = rdc[k] - r0;
    dwr = wrc[k] - w0;
  endtask

  task automatic run_chk(input int k, input bit w, input int blk, input int off,
                         input logic [31:0] d, output bit hit);
    bit eh;
    logic [31:0] rd;
    int cyc, drd, dwr;
    logic [31:0] a;
    a  = 32'(blk * 4 + off);
    eh = ref_access(k, w, blk);
    access(k, w, a, d, rd, cyc, drd, dwr);
    if (w) begin
      refmem[k][blk] = d;
      hit = eh;
      chk(dwr == 1 && drd == 0, "R12 one write per store", dwr, 1);
      chk(lastw[k] == d, "R5 store data", lastw[k], d);
      chk(lasta[k] == 32'(blk * 4), "R5 store address aligned", lasta[k], blk * 4);
    end else begin
      hit = (drd == 0);
      chk(hit == eh, "R9 hit/miss vs recency order", hit, eh);
      chk(rd == refmem[k][blk], eh ? "R3 hit data" : "R4 refill data", rd, refmem[k][blk]);
      if (eh) chk(cyc == 1 && dwr == 0, "R2 hit in one cycle", cyc, 1);
      else begin
        chk(drd == 1 && dwr == 0, "R12 one read per miss", drd, 1);
        chk(lasta[k] == 32'(blk * 4), "R4 refill address aligned", lasta[k], blk * 4);
      end
    end
  endtask

  task automatic dchk(input int k, input int blk, input int off, input bit exp_hit, input string rq);
    bit h;
    run_chk(k, 1'b0, blk, off, 32'h0, h);
    chk(h == exp_hit, rq, h, exp_hit);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] x;
    for (int k = 0; k < NCFG; k++) begin
      req[k] = 1'b0; we[k] = 1'b0; addr[k] = '0; wdata[k] = '0;
      for (int s = 0; s < 4; s++) dep[k][s] = 0;
      for (int i = 0; i < 64; i++) refmem[k][i] = init_word(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NCFG; k++) begin
      chk(ready[k] == 1'b0, "R10 ready low after reset", ready[k], 0);
      chk(mrd[k] == 1'b0 && mwr[k] == 1'b0, "R10 no command after reset", {mrd[k], mwr[k]}, 0);
    end

    // R11: the three four-entry shapes on blocks 0,8,0,6,8
    dchk(1, 0, 0, 1'b0, "R11 dm #1"); dchk(1, 8, 0, 1'b0, "R11 dm #2");
    dchk(1, 0, 0, 1'b0, "R11 dm #3"); dchk(1, 6, 0, 1'b0, "R11 dm #4");
    dchk(1, 8, 0, 1'b0, "R11 dm #5");
    dchk(2, 0, 0, 1'b0, "R11 2w #1"); dchk(2, 8, 0, 1'b0, "R11 2w #2");
    dchk(2, 0, 0, 1'b1, "R11 2w #3"); dchk(2, 6, 0, 1'b0, "R11 2w #4");
    dchk(2, 8, 0, 1'b0, "R11 2w #5");
    dchk(3, 0, 0, 1'b0, "R11 fa #1"); dchk(3, 8, 0, 1'b0, "R11 fa #2");
    dchk(3, 0, 0, 1'b1, "R11 fa #3"); dchk(3, 6, 0, 1'b0, "R11 fa #4");
    dchk(3, 8, 0, 1'b1, "R11 fa #5");

    // R10 first read misses, R1 byte offset ignored
    dchk(0, 16, 0, 1'b0, "R10 first read misses");
    dchk(0, 16, 3, 1'b1, "R1 offset 3 same entry");
    dchk(0, 16, 1, 1'b1, "R1 offset 1 same entry");
    dchk(0, 17, 2, 1'b0, "R1 next word is another entry");

    // R8 fill four ways of set 2, all stay resident
    dchk(0, 2, 0, 1'b0, "R8 fill a"); dchk(0, 6, 0, 1'b0, "R8 fill b");
    dchk(0, 10, 0, 1'b0, "R8 fill c"); dchk(0, 14, 0, 1'b0, "R8 fill d");
    dchk(0, 2, 0, 1'b1, "R8 resident a"); dchk(0, 6, 0, 1'b1, "R8 resident b");
    dchk(0, 10, 0, 1'b1, "R8 resident c"); dchk(0, 14, 0, 1'b1, "R8 resident d");

    // R6 / R9 store hit refreshes recency; LRU victim choice
    run_chk(0, 1'b1, 2, 0, 32'hDEAD_0002, h);
    dchk(0, 18, 0, 1'b0, "R9 new block misses");
    dchk(0, 6, 0, 1'b0, "R9 least recent block evicted");
    dchk(0, 2, 0, 1'b1, "R6 store hit kept and updated");
    dchk(0, 14, 0, 1'b1, "R9 more recent block kept");

    // R7 store miss does not allocate
    run_chk(0, 1'b1, 22, 0, 32'hBEEF_0022, h);
    dchk(0, 22, 0, 1'b0, "R7 read after store miss misses");
    dchk(0, 22, 2, 1'b1, "R7 then hits");

    // Sweep: mixed loads and stores over all configurations
    x = 32'h1234_5678;
    for (int i = 0; i < 800; i++) begin
      int k, blk, off;
      bit w;
      x   = x * 32'd1103515245 + 32'd12345;
      k   = i % NCFG;
      blk = int'((x >> 16) % 24);
      w   = ((x >> 8) % 4) == 0;
      off = int'((x >> 4) % 4);
      run_chk(k, w, blk, off, x ^ 32'h5A5A_A5A5, h);
    end

    summary();
    $finish;
  end

endmodule